// File: doc/BRIEF.md
# Interrupt Configuration Bank and Forwarding Filter

This block holds per-interrupt settings for a fixed set of interrupt IDs: an urgency value, a group code, a trigger mode and an enable bit. Software programs the first three through a single-field write port and reads any field back through a combinational read port. Enables have no read-modify-write path. A write-1-to-set vector turns bits on and a write-1-to-clear vector turns them off.

Raw interrupt wires feed a simple pending model. A level-mode ID is pending for as long as its wire is high. An edge-mode ID latches pending on a rising edge and stays pending until it is cleared explicitly.

Every cycle a combinational filter finds the most urgent pending ID that passes all gates: its own enable, the urgency mask, and both the system-wide and the interface-level enable of its group. The filter reports that ID and its urgency to the processor side. IDs 0 to 15 are software-generated, 16 to 31 are private peripherals, and 32 and above are shared.

Top module: `irq_cfg_filter`

## Requirements
- R1: After reset every urgency reads 0, every group reads 0, every enable reads 0, and the trigger field reads 1 for IDs 0–15 and 0 for all other IDs. `fwd_valid` is low.
- R2: Urgency is 8 bits, where 0x00 is most urgent and 0xFF is least urgent. Only the top `PRIO_BITS` bits are stored. A read returns those bits with the low `8-PRIO_BITS` bits as zero.
- R3: A 1 on `en_set[i]` enables ID i and a 1 on `en_clr[i]` disables it, starting from the next cycle. Zero bits leave the enable unchanged. When both are 1 in the same cycle, the clear wins.
- R4: For IDs 0–15 the trigger field always reads 1 (edge), and writes to it are ignored. For other IDs, trigger 1 selects edge mode and 0 selects level mode.
- R5: An ID is forwarded only if its urgency value is strictly less than `prio_mask`.
- R6: Group codes are 0 (group 0), 1 (secure group 1) and 2 (non-secure group 1). An ID is forwarded only if bit g of both `glb_en` and `if_en` is 1, where g is its group code. Group code 3 is never forwarded.
- R7: An ID whose own enable is 0 is never forwarded.
- R8: Among eligible IDs, the one with the lowest urgency value wins. On a tie, the lowest ID wins.
- R9: A level-mode ID is pending exactly while its `irq_in` bit is high. The filter output responds in the same cycle.
- R10: An edge-mode ID becomes pending in the cycle after a rising edge on `irq_in` and stays pending after the input falls. A 1 on `pend_clr` clears it. If a new rising edge and a clear arrive in the same cycle, the new edge wins.
- R11: Field select codes are 0 (urgency), 1 (group, bits 1:0), 2 (trigger, bit 0) and 3 (enable, bit 0; read only). Writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Field write strobe |
| cfg_field | input | 2 | Field select for the write |
| cfg_id | input | IDW | ID to write |
| cfg_wdata | input | 8 | Write data |
| rd_field | input | 2 | Field select for the read |
| rd_id | input | IDW | ID to read |
| rd_data | output | 8 | Read data (combinational) |
| en_set | input | NUM_IDS | Write-1-to-set enables |
| en_clr | input | NUM_IDS | Write-1-to-clear enables |
| irq_in | input | NUM_IDS | Raw interrupt wires |
| pend_clr | input | NUM_IDS | Clear edge-latched pending |
| prio_mask | input | 8 | Urgency mask |
| glb_en | input | 3 | System-wide group enables |
| if_en | input | 3 | Interface group enables |
| fwd_valid | output | 1 | An ID is forwarded |
| fwd_id | output | IDW | Forwarded ID |
| fwd_prio | output | 8 | Urgency of the forwarded ID |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Mask boundary:** it sweeps `prio_mask` through every value around a fixed urgency. A design that compared with less-or-equal would forward at the equal value.
- **Group gating:** it runs every group code against all 64 combinations of the two enable layers. A design that OR-ed the layers, or that let code 3 through, would forward wrongly.
- **Arbitration:** it uses urgency patterns truncated to 5 bits, which creates ties. A design that favoured the highest ID, or that compared untruncated values, would pick the wrong winner.
- **Edge and enable races:** the edge tests cover the pending state holding after the input falls, and a new edge arriving together with a clear. The enable tests cover set and clear arriving together. Getting any of these priorities backwards loses the interrupt.

// File: rtl/irq_cfg_filter.sv
module irq_cfg_filter #(
  parameter int NUM_IDS   = 64,
  parameter int PRIO_BITS = 5,
  localparam int IDW      = $clog2(NUM_IDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_field,
  input  logic [IDW-1:0]     cfg_id,
  input  logic [7:0]         cfg_wdata,
  input  logic [1:0]         rd_field,
  input  logic [IDW-1:0]     rd_id,
  output logic [7:0]         rd_data,
  input  logic [NUM_IDS-1:0] en_set,
  input  logic [NUM_IDS-1:0] en_clr,
  input  logic [NUM_IDS-1:0] irq_in,
  input  logic [NUM_IDS-1:0] pend_clr,
  input  logic [7:0]         prio_mask,
  input  logic [2:0]         glb_en,
  input  logic [2:0]         if_en,
  output logic               fwd_valid,
  output logic [IDW-1:0]     fwd_id,
  output logic [7:0]         fwd_prio
);
  localparam int SGI_N = 16;
  localparam int LOWB  = 8 - PRIO_BITS;
  localparam logic [1:0] F_PRIO = 2'd0, F_GRP = 2'd1, F_TRIG = 2'd2, F_EN = 2'd3;

  logic [PRIO_BITS-1:0] prio_q [NUM_IDS];
  logic [1:0]           grp_q  [NUM_IDS];
  logic [7:0]           p8     [NUM_IDS];
  logic [NUM_IDS-1:0]   trig_q, en_q, edge_q, irq_d, pend, elig;
  logic [3:0]           gate;

  assign gate = {1'b0, glb_en & if_en};

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[i] <= '0;
        grp_q[i]  <= '0;
        trig_q[i] <= (i < SGI_N);
      end else if (cfg_we && cfg_id == IDW'(i)) begin
        case (cfg_field)
          F_PRIO:  prio_q[i] <= cfg_wdata[7 -: PRIO_BITS];
          F_GRP:   grp_q[i]  <= cfg_wdata[1:0];
          F_TRIG:  trig_q[i] <= (i < SGI_N) | cfg_wdata[0];
          default: ;
        endcase
      end
    end
    assign p8[i]   = 8'(prio_q[i]) << LOWB;
    assign pend[i] = trig_q[i] ? edge_q[i] : irq_in[i];
    assign elig[i] = pend[i] & en_q[i] & gate[grp_q[i]] & (p8[i] < prio_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      edge_q <= '0;
      irq_d  <= '0;
    end else begin
      en_q   <= (en_q | en_set) & ~en_clr;
      edge_q <= ((edge_q & ~pend_clr) | (irq_in & ~irq_d)) & trig_q;
      irq_d  <= irq_in;
    end
  end

  always_comb begin
    fwd_valid = 1'b0;
    fwd_id    = '0;
    fwd_prio  = 8'hFF;
    for (int i = 0; i < NUM_IDS; i++) begin
      if (elig[i] && (!fwd_valid || p8[i] < fwd_prio)) begin
        fwd_valid = 1'b1;
        fwd_id    = IDW'(i);
        fwd_prio  = p8[i];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_id) < NUM_IDS) begin
      case (rd_field)
        F_PRIO:  rd_data = p8[rd_id];
        F_GRP:   rd_data = {6'b0, grp_q[rd_id]};
        F_TRIG:  rd_data = {7'b0, trig_q[rd_id]};
        default: rd_data = {7'b0, en_q[rd_id]};
      endcase
    end
  end

  if (LOWB > 0) begin : g_lowchk
    p_lowbits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_field == F_PRIO) |-> (rd_data[LOWB-1:0] == '0));
  end

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set != '0) |=> ((en_q & $past(en_set & ~en_clr)) == $past(en_set & ~en_clr)));
  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr != '0) |=> ((en_q & $past(en_clr)) == '0));
  p_sgi_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_field == F_TRIG && int'(rd_id) < SGI_N) |-> (rd_data == 8'd1));
  p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_prio < prio_mask));
  p_grp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (grp_q[fwd_id] != 2'd3 && glb_en[grp_q[fwd_id]] && if_en[grp_q[fwd_id]]));
  p_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> en_q[fwd_id]);
endmodule

// File: tb/sim_irq_cfg_filter.sv
`timescale 1ns/1ps
module sim_irq_cfg_filter;
  localparam int N = 48, PB = 5, IDW = $clog2(N);
  localparam logic [7:0] KEEP = 8'hF8;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_field = 0, rd_field = 0;
  logic [IDW-1:0] cfg_id = 0, rd_id = 0, fwd_id;
  logic [7:0] cfg_wdata = 0, rd_data, prio_mask = 8'hFF, fwd_prio;
  logic [N-1:0] en_set = 0, en_clr = 0, irq_in = 0, pend_clr = 0;
  logic [2:0] glb_en = 3'b111, if_en = 3'b111;
  logic fwd_valid;

  int n_chk = 0, n_fail = 0;
  int m_prio [N];

  always #2.5 clk = ~clk;

  irq_cfg_filter #(.NUM_IDS(N), .PRIO_BITS(PB)) u0 (
    .clk, .rst_n, .cfg_we, .cfg_field, .cfg_id, .cfg_wdata, .rd_field, .rd_id, .rd_data,
    .en_set, .en_clr, .irq_in, .pend_clr, .prio_mask, .glb_en, .if_en,
    .fwd_valid, .fwd_id, .fwd_prio);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] f, input int id, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_field = f; cfg_id = IDW'(id); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input logic [1:0] f, input int id, output int d);
    rd_field = f; rd_id = IDW'(id);
    #0.5;
    d = int'(rd_data);
  endtask

  task automatic pulse_en(input logic [N-1:0] s, input logic [N-1:0] c);
    @(negedge clk);
    en_set = s; en_clr = c;
    @(negedge clk);
    en_set = '0; en_clr = '0;
  endtask

  task automatic exp_fwd(output bit v, output int id, output int p);
    v = 0; id = 0; p = 255;
    for (int i = 16; i < N; i++)
      if (irq_in[i] && m_prio[i] < int'(prio_mask) && (!v || m_prio[i] < p)) begin
        v = 1; id = i; p = m_prio[i];
      end
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d; bit v; int eid, ep;
    #12 rst_n = 1;
    // R1: reset state across all IDs
    #0.5;
    chk(fwd_valid == 0, "R1 fwd", int'(fwd_valid), 0);
    for (int i = 0; i < N; i++) begin
      rd(0, i, d); chk(d == 0, "R1 prio", d, 0);
      rd(1, i, d); chk(d == 0, "R1 grp", d, 0);
      rd(2, i, d); chk(d == int'(i < 16), "R1 trig", d, int'(i < 16));
      rd(3, i, d); chk(d == 0, "R1 en", d, 0);
    end
    // R2 / R11: urgency truncation on readback
    for (int i = 0; i < N; i++) begin
      wr(0, i, (i * 37 + 11) & 255);
      m_prio[i] = ((i * 37 + 11) & 255) & int'(KEEP);
    end
    for (int i = 0; i < N; i++) begin
      rd(0, i, d); chk(d == m_prio[i], "R2 prio readback", d, m_prio[i]);
    end
    // R4: trigger field forced to edge for software-generated IDs
    for (int i = 0; i < N; i++) wr(2, i, 0);
    for (int i = 0; i < N; i++) begin
      rd(2, i, d); chk(d == int'(i < 16), "R4 trig after 0", d, int'(i < 16));
    end
    for (int i = 0; i < N; i++) wr(2, i, 1);
    for (int i = 0; i < N; i++) begin
      rd(2, i, d); chk(d == 1, "R4 trig after 1", d, 1);
    end
    for (int i = 16; i < N; i++) wr(2, i, 0);
    // R3: set, clear, zero no effect, clear wins
    pulse_en({N/3{3'b101}}, '0);
    for (int i = 0; i < N; i++) begin
      rd(3, i, d); chk(d == int'(i % 3 != 1), "R3 set", d, int'(i % 3 != 1));
    end
    pulse_en('0, {N/3{3'b001}});
    for (int i = 0; i < N; i++) begin
      rd(3, i, d); chk(d == int'(i % 3 == 2), "R3 clear", d, int'(i % 3 == 2));
    end
    pulse_en({N{1'b1}}, {N/2{2'b01}});
    for (int i = 0; i < N; i++) begin
      rd(3, i, d); chk(d == int'(i % 2 == 1), "R3 clear wins", d, int'(i % 2 == 1));
    end
    pulse_en({N{1'b1}}, '0);
    // R8 / R9: arbitration sweep over level patterns with ties
    for (int k = 0; k < 8; k++) begin
      for (int i = 16; i < N; i++) begin
        wr(0, i, (i * 13 + k * 29) & 255);
        m_prio[i] = ((i * 13 + k * 29) & 255) & int'(KEEP);
      end
      @(negedge clk);
      for (int i = 16; i < N; i++) irq_in[i] = ((i * 7 + k) % 3) != 0;
      prio_mask = (k % 2 == 0) ? 8'hFF : 8'h90;
      #0.5;
      exp_fwd(v, eid, ep);
      chk(fwd_valid == v, "R8 valid", int'(fwd_valid), int'(v));
      chk(int'(fwd_id) == eid, "R8 winner", int'(fwd_id), eid);
      chk(int'(fwd_prio) == ep, "R8 prio", int'(fwd_prio), ep);
    end
    // R8: explicit tie resolves to lowest ID
    @(negedge clk); irq_in = '0; prio_mask = 8'hFF;
    wr(0, 25, 8'h40); wr(0, 22, 8'h47); wr(0, 35, 8'h40);
    @(negedge clk); irq_in[25] = 1; irq_in[22] = 1; irq_in[35] = 1;
    #0.5;
    chk(int'(fwd_id) == 22, "R8 tie lowest id", int'(fwd_id), 22);
    // R5: strict mask comparison
    @(negedge clk); irq_in = '0;
    pulse_en('0, {N{1'b1}});
    pulse_en(N'(1) << 40, '0);
    wr(0, 40, 8'h50);
    @(negedge clk); irq_in[40] = 1;
    for (int m = 0; m < 256; m++) begin
      prio_mask = 8'(m);
      #0.5;
      chk(fwd_valid == (m > 'h50), "R5 mask", int'(fwd_valid), int'(m > 'h50));
    end
    prio_mask = 8'hFF;
    // R6: group code against both enable layers
    for (int g = 0; g < 4; g++) begin
      wr(1, 40, g);
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++) begin
          glb_en = 3'(a); if_en = 3'(b);
          #0.5;
          v = (g < 3) && a[g] && b[g];
          chk(fwd_valid == v, "R6 group gate", int'(fwd_valid), int'(v));
        end
    end
    glb_en = 3'b111; if_en = 3'b111;
    wr(1, 40, 0);
    // R7: per-ID enable
    pulse_en('0, N'(1) << 40);
    #0.5; chk(fwd_valid == 0, "R7 disabled", int'(fwd_valid), 0);
    pulse_en(N'(1) << 40, '0);
    #0.5; chk(fwd_valid == 1, "R7 enabled", int'(fwd_valid), 1);
    // R9: level follows input in the same cycle
    @(negedge clk); irq_in = '0;
    pulse_en(N'(1) << 31, '0);
    wr(0, 31, 8'h10);
    @(negedge clk); irq_in[31] = 1; #0.5;
    chk(fwd_valid && fwd_id == 31, "R9 level high", int'(fwd_id), 31);
    @(negedge clk); irq_in[31] = 0; #0.5;
    chk(fwd_valid == 0, "R9 level low", int'(fwd_valid), 0);
    // R10: edge latch, hold, clear, edge beats clear
    wr(2, 30, 1); wr(0, 30, 8'h08);
    pulse_en(N'(1) << 30, '0);
    @(negedge clk); irq_in[30] = 1; #0.5;
    chk(fwd_valid == 0, "R10 not yet latched", int'(fwd_valid), 0);
    @(negedge clk); #0.5;
    chk(fwd_valid && fwd_id == 30, "R10 latched", int'(fwd_id), 30);
    irq_in[30] = 0;
    @(negedge clk); #0.5;
    chk(fwd_valid && fwd_id == 30, "R10 held", int'(fwd_valid), 1);
    pend_clr[30] = 1;
    @(negedge clk); pend_clr = '0; #0.5;
    chk(fwd_valid == 0, "R10 cleared", int'(fwd_valid), 0);
    irq_in[30] = 1; pend_clr[30] = 1;
    @(negedge clk); pend_clr = '0; #0.5;
    chk(fwd_valid && fwd_id == 30, "R10 edge beats clear", int'(fwd_valid), 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule